// File: doc/BRIEF.md
# Transfer Counter and Address Sequencer

This block holds the transfer state of one channel of a small data-transfer engine. The state is a source address, a destination address and two count registers. Each transfer strobe advances that state. The addresses step by the transfer size or stay fixed, and the counters count down. In the two split modes the low half of count A reloads itself from its high half. A one-cycle pulse marks the end of a block, and another marks the end of the whole transfer. A word transfer is refused when either address is odd.

Software or a descriptor engine programs the four registers through a simple load port. The controlling logic then issues one strobe per moved datum and watches the pulses. The mode input selects one of three behaviours: a single 16-bit count, a repeating ring, or blocks counted by a second register. The size input selects byte or word.

Top module: `xfer_seq`

## Requirements
- R1: While `rst_n` is low, both addresses and both counts are zero, and `done`, `blk_end` and `align_err` are low.
- R2: When `ld_en` is high, `ld_data` is written to the register chosen by `ld_sel`: 0 source, 1 destination, 2 count A (low 16 bits), 3 count B (low 16 bits). A strobe in the same cycle is ignored. With neither load nor strobe, all state holds.
- R3: Mode codes are 00 normal, 01 repeat, 10 block, and 11 acts as normal. In normal mode each strobe decrements the 16-bit count A. `done` pulses in the cycle after a strobe that takes it from 1 to 0. A strobe at 0 wraps it to FFFF with no `done`.
- R4: In repeat and block modes, count A bits [7:0] decrement per strobe and bits [15:8] never change. A strobe at 1 reloads bits [7:0] from bits [15:8] and pulses `blk_end` one cycle later. A strobe at 0 wraps bits [7:0] to FF with no reload.
- R5: In block mode each strobe also decrements count B, and `done` pulses when count B goes from 1 to 0. A strobe at 0 wraps it to FFFF with no `done`. In the other modes count B holds.
- R6: On a strobe each address with its increment input high advances by 1 (byte, `word`=0) or by 2 (`word`=1), modulo 2^24. An address with its increment input low holds.
- R7: In repeat mode, the address chosen by `rpt_dst` (0 source, 1 destination) returns to its last loaded value on a reload. Repeat mode never pulses `done`.
- R8: A strobe with `word`=1 while either address is odd pulses `align_err` for one cycle and changes no address and no count.
- R9: In block mode, a strobe that ends both a block and count B raises `done` and `blk_end` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Register select for the load |
| ld_data | input | 24 | Load value |
| mode | input | 2 | 00 normal, 01 repeat, 10 block, 11 normal |
| word | input | 1 | 1 selects word size, 0 selects byte size |
| src_inc | input | 1 | Source address steps when high |
| dst_inc | input | 1 | Destination address steps when high |
| rpt_dst | input | 1 | Side restored in repeat mode: 1 destination, 0 source |
| xfer | input | 1 | Transfer strobe |
| src_addr | output | 24 | Source address |
| dst_addr | output | 24 | Destination address |
| cnt_a | output | 16 | Count A |
| cnt_b | output | 16 | Count B |
| done | output | 1 | End-of-transfer pulse |
| blk_end | output | 1 | Reload (block end) pulse |
| align_err | output | 1 | Odd word address pulse |

## Verification
In block mode the reload of the low byte of count A and the exhaustion of count B can fall on one strobe. The bench provokes this by programming a block size that divides count B and stepping until both reach zero. It then requires `done` and `blk_end` high together in the following cycle, with count A showing the reloaded value. Randomised traffic also lands loads on strobes and odd word addresses on strobes. A behavioural model, compared every cycle, judges both the priority of load over strobe and the refusal of misaligned word transfers.

// File: rtl/xfer_seq.sv
module xfer_seq #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [AW-1:0] ld_data,
  input  logic [1:0]    mode,
  input  logic          word,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic          rpt_dst,
  input  logic          xfer,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic          done,
  output logic          blk_end,
  output logic          align_err
);
  localparam int HW = CW / 2;

  logic [AW-1:0] src_q, dst_q, src_init, dst_init;
  logic [CW-1:0] cnta_q, cntb_q;
  logic          done_q, blk_q, err_q;

  logic          go, odd, step, is_rpt, is_blk, split, lo_hit, fin;
  logic [HW-1:0] lo, hi;
  logic [AW-1:0] inc, src_nx, dst_nx;
  logic [CW-1:0] cnta_nx, cntb_nx;

  assign go     = xfer && !ld_en;
  assign odd    = word && (src_q[0] || dst_q[0]);
  assign step   = go && !odd;
  assign is_rpt = (mode == 2'b01);
  assign is_blk = (mode == 2'b10);
  assign split  = is_rpt || is_blk;
  assign lo     = cnta_q[HW-1:0];
  assign hi     = cnta_q[CW-1:HW];
  assign lo_hit = split && (lo == HW'(1));
  assign inc    = word ? AW'(2) : AW'(1);

  assign src_nx = (is_rpt && lo_hit && !rpt_dst) ? src_init :
                  src_inc ? src_q + inc : src_q;
  assign dst_nx = (is_rpt && lo_hit && rpt_dst) ? dst_init :
                  dst_inc ? dst_q + inc : dst_q;

  assign cnta_nx = split ? {hi, (lo_hit ? hi : lo - HW'(1))} : cnta_q - CW'(1);
  assign cntb_nx = is_blk ? cntb_q - CW'(1) : cntb_q;
  assign fin     = (!split && cnta_q == CW'(1)) || (is_blk && cntb_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      src_init <= '0;
      dst_init <= '0;
      cnta_q   <= '0;
      cntb_q   <= '0;
      done_q   <= 1'b0;
      blk_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= step && fin;
      blk_q  <= step && lo_hit;
      err_q  <= go && odd;
      if (ld_en) begin
        case (ld_sel)
          2'd0: begin src_q <= ld_data; src_init <= ld_data; end
          2'd1: begin dst_q <= ld_data; dst_init <= ld_data; end
          2'd2: cnta_q <= ld_data[CW-1:0];
          default: cntb_q <= ld_data[CW-1:0];
        endcase
      end else if (step) begin
        src_q  <= src_nx;
        dst_q  <= dst_nx;
        cnta_q <= cnta_nx;
        cntb_q <= cntb_nx;
      end
    end
  end

  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign cnt_a     = cnta_q;
  assign cnt_b     = cntb_q;
  assign done      = done_q;
  assign blk_end   = blk_q;
  assign align_err = err_q;
endmodule

module xfer_seq_chk #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_en,
  input logic [1:0]    mode,
  input logic          xfer,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic          done,
  input logic          blk_end,
  input logic          align_err
);
  localparam int HW = CW / 2;

  // R3
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(xfer && !ld_en));

  // R7
  rpt_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mode) != 2'b01);

  // R4
  reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> cnt_a[HW-1:0] == cnt_a[CW-1:HW]);

  // R8
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> $stable(src_addr) && $stable(dst_addr) && $stable(cnt_a) && $stable(cnt_b));

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !done && !blk_end);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(xfer) && !$past(ld_en)) |->
      $stable(src_addr) && $stable(dst_addr) && $stable(cnt_a) && $stable(cnt_b));
endmodule

bind xfer_seq xfer_seq_chk #(.AW(AW), .CW(CW)) chk_i (.*);

// File: tb/xfer_seq_tb_top.sv
`timescale 1ns/1ps
module xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [23:0] ld_data = '0;
  logic [1:0]  mode = '0;
  logic        word = 1'b0, src_inc = 1'b0, dst_inc = 1'b0, rpt_dst = 1'b0, xfer = 1'b0;
  logic [23:0] src_addr, dst_addr;
  logic [15:0] cnt_a, cnt_b;
  logic        done, blk_end, align_err;

  int total = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfer_seq dut_i (.*);

  // behavioural reference
  int m_src, m_dst, m_srci, m_dsti, m_a, m_b;
  bit m_done, m_blk, m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_srci = 0; m_dsti = 0; m_a = 0; m_b = 0;
      m_done = 0; m_blk = 0; m_err = 0;
    end else begin
      m_done = 0; m_blk = 0; m_err = 0;
      if (ld_en) begin
        case (ld_sel)
          0: begin m_src = int'(ld_data); m_srci = m_src; end
          1: begin m_dst = int'(ld_data); m_dsti = m_dst; end
          2: m_a = int'(ld_data) % 65536;
          default: m_b = int'(ld_data) % 65536;
        endcase
      end else if (xfer) begin
        if (word && ((m_src % 2) == 1 || (m_dst % 2) == 1)) m_err = 1;
        else begin
          int st;
          bit reload;
          st = word ? 2 : 1;
          reload = 0;
          if (mode == 2'b01 || mode == 2'b10) begin
            int lo, hi;
            lo = m_a % 256; hi = m_a / 256;
            if (lo == 1) begin reload = 1; lo = hi; m_blk = 1; end
            else lo = (lo + 255) % 256;
            m_a = hi * 256 + lo;
          end else begin
            if (m_a == 1) m_done = 1;
            m_a = (m_a + 65535) % 65536;
          end
          if (mode == 2'b10) begin
            if (m_b == 1) m_done = 1;
            m_b = (m_b + 65535) % 65536;
          end
          if (mode == 2'b01 && reload && !rpt_dst) m_src = m_srci;
          else if (src_inc) m_src = (m_src + st) % 16777216;
          if (mode == 2'b01 && reload && rpt_dst) m_dst = m_dsti;
          else if (dst_inc) m_dst = (m_dst + st) % 16777216;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(src_addr === 24'(m_src), "R6 src_addr", int'(src_addr), m_src);
    chk(dst_addr === 24'(m_dst), "R6 dst_addr", int'(dst_addr), m_dst);
    chk(cnt_a === 16'(m_a), "R3/R4 cnt_a", int'(cnt_a), m_a);
    chk(cnt_b === 16'(m_b), "R5 cnt_b", int'(cnt_b), m_b);
    chk(done === m_done, "R3/R5 done", int'(done), int'(m_done));
    chk(blk_end === m_blk, "R4 blk_end", int'(blk_end), int'(m_blk));
    chk(align_err === m_err, "R8 align_err", int'(align_err), int'(m_err));
  end

  task automatic idle();
    ld_en = 0; xfer = 0;
    @(negedge clk);
  endtask

  task automatic load(input logic [1:0] sel, input logic [23:0] val);
    ld_en = 1; ld_sel = sel; ld_data = val; xfer = 0;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic strobe();
    ld_en = 0; xfer = 1;
    @(negedge clk);
    xfer = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(src_addr == 0 && dst_addr == 0, "R1 addr reset", int'(src_addr), 0);
    chk(cnt_a == 0 && cnt_b == 0, "R1 count reset", int'(cnt_a), 0);
    chk(!done && !blk_end && !align_err, "R1 flags reset", int'(done), 0);
    rst_n = 1;
    idle();

    // R3 normal mode, byte, both increment
    mode = 2'b00; word = 0; src_inc = 1; dst_inc = 1;
    load(0, 24'h000100); load(1, 24'h000200); load(2, 24'h3);
    strobe(); strobe();
    chk(!done, "R3 no early done", int'(done), 0);
    strobe();
    chk(done && cnt_a == 0, "R3 done at zero", int'(done), 1);
    chk(src_addr == 24'h103, "R6 byte step", int'(src_addr), 'h103);
    idle();
    chk(!done, "R3 done one cycle", int'(done), 0);

    // R3 zero wraps
    load(2, 24'h0);
    strobe();
    chk(cnt_a == 16'hFFFF && !done, "R3 zero wrap", int'(cnt_a), 'hFFFF);

    // R2 load wins over strobe
    ld_en = 1; ld_sel = 2; ld_data = 24'h55; xfer = 1;
    @(negedge clk);
    ld_en = 0; xfer = 0;
    chk(cnt_a == 16'h55, "R2 load priority", int'(cnt_a), 'h55);

    // R8 odd word address
    word = 1;
    load(0, 24'h000101);
    strobe();
    chk(align_err && src_addr == 24'h101 && cnt_a == 16'h55, "R8 odd refused", int'(src_addr), 'h101);
    idle();

    // R6 wrap and fixed address
    word = 0; src_inc = 1; dst_inc = 0;
    load(0, 24'hFFFFFF); load(1, 24'h000400);
    strobe();
    chk(src_addr == 0 && dst_addr == 24'h400, "R6 wrap/fixed", int'(src_addr), 0);

    // R7 repeat restore destination
    mode = 2'b01; word = 1; src_inc = 1; dst_inc = 1; rpt_dst = 1;
    load(0, 24'h001000); load(1, 24'h000300); load(2, 24'h0202);
    strobe();
    strobe();
    chk(blk_end && dst_addr == 24'h300, "R7 dst restored", int'(dst_addr), 'h300);
    chk(src_addr == 24'h1004 && !done, "R7 src steps, no done", int'(src_addr), 'h1004);
    chk(cnt_a == 16'h0202, "R4 reload value", int'(cnt_a), 'h0202);

    // R4 low byte zero wraps
    mode = 2'b10; word = 0;
    load(2, 24'h0300); load(3, 24'h10);
    strobe();
    chk(cnt_a == 16'h03FF && !blk_end, "R4 low wrap", int'(cnt_a), 'h03FF);

    // R9 block end and done together
    load(2, 24'h0202); load(3, 24'h4);
    strobe(); strobe();
    chk(blk_end && !done, "R4 block end only", int'(blk_end), 1);
    strobe(); strobe();
    chk(done && blk_end, "R9 coincide", int'({done, blk_end}), 3);
    chk(cnt_b == 0 && cnt_a == 16'h0202, "R9 counters", int'(cnt_b), 0);

    // R5 count B wrap and hold outside block mode
    load(3, 24'h0);
    strobe();
    chk(cnt_b == 16'hFFFF && !done, "R5 zero wrap", int'(cnt_b), 'hFFFF);
    mode = 2'b00;
    strobe();
    chk(cnt_b == 16'hFFFF, "R5 hold in normal", int'(cnt_b), 'hFFFF);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      ld_en = ($urandom % 6) == 0;
      ld_sel = 2'($urandom);
      ld_data = ($urandom % 4 == 0) ? 24'($urandom % 4) : 24'($urandom);
      xfer = ($urandom % 3) != 0;
      if (i % 50 == 0) begin
        mode = 2'($urandom); word = 1'($urandom);
        src_inc = 1'($urandom); dst_inc = 1'($urandom); rpt_dst = 1'($urandom);
      end
      @(negedge clk);
    end
    idle();

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule